// File: doc/BRIEF.md
# Vectored Nested Priority Interrupt Controller

The block gathers interrupt requests from eight sources, each with its own programmable 3-bit priority level. It keeps them in request flags and picks the most urgent one. It raises a single interrupt line toward an 8-bit CPU, together with a 3-bit vector index that names the winning source, so the handler can be entered directly. A running handler is interrupted only by a strictly more urgent request. The levels currently being serviced are held as a bitmap, so handlers nest. Software ends a handler by writing to a return register, and this lets lower levels resume.

The CPU programs the block through six write-only byte locations. Offset 0 is a low-active control byte. Offsets 1 to 4 are priority bytes, each covering two sources. Offset 5 is the return register. Some control bits fire once, during the write itself. Others are stored: a global disable, and a "stop after one interrupt" mode that software must re-arm for each further interrupt. The CPU confirms that it has taken the interrupt by raising `ack_i` while `irq_o` is high.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After `rst_n` is low, `irq_o` is 0, `vec_o` is 0, every priority is 0, no request flag or in-service level is set, and both stored control bits are inactive.
- R2: A write to offset k (1 to 4) sets source index 2k-1 from data bits 6..4 and source index 2k-2 from data bits 2..0. Bits 7 and 3 are ignored. Source index i is reported as `vec_o` = i.
- R3: A source whose priority is 0 never raises `irq_o`, even when its request flag is set.
- R4: Among flagged sources with a nonzero priority, the highest priority wins. On a tie, the lowest source index wins.
- R5: If `req_i` is high on one rising edge, `irq_o` and `vec_o` are valid after the next rising edge, which is within 3 cycles.
- R6: `irq_o` rises only when the winner's priority is strictly greater than the highest in-service level. An equal or lower request stays flagged and is served later.
- R7: A cycle with `ack_i` and `irq_o` both high clears the flag of the source in `vec_o`, marks its level as in service, and drops `irq_o` on the next edge. A new request from that same source in that same cycle stays flagged.
- R8: A write of any data to offset 5 removes the highest in-service level.
- R9: Control bit 2 written as 0 is stored and disables interrupts. Flags are still set, and writing the bit back to 1 lets the pending request through.
- R10: A control write with bit 0 = 0 clears every request flag in that cycle, and this wins over a request arriving in the same cycle.
- R11: While stored control bit 3 is 0, taking one interrupt blocks all further ones until a control write with bit 1 = 0.
- R12: A control write with bit 4 = 0 clears all flags, all in-service levels and the block, drops `irq_o`, and returns bits 2 and 3 to 1. The priorities are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, low active |
| req_i | input | 8 | Request per source, sampled each edge |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | 3 | Register offset 0 to 5 |
| wr_data | input | 8 | Write data |
| ack_i | input | 1 | CPU takes the interrupt shown on vec_o |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 3 | Index of the source being requested |

## Verification
Two functions can hit one source flag in the same cycle: the acknowledge clears it, and a fresh request from that source sets it. The bench drives `ack_i` and that source's `req_i` in the same cycle. It then checks that no interrupt follows while the level is still in service, and that exactly one interrupt for that source appears once the return register is written. A second collision is a clear-all pulse on the same cycle as a new request. The bench judges it by the absence of any interrupt after interrupts are enabled again.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NUM_SRC = 8;
  localparam int LVL_W   = 3;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int NUM_LVL = 1 << LVL_W;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;
  localparam int NIB     = DATA_W / 2;
  localparam int NUM_PB  = NUM_SRC / 2;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_PRIO = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_RET  = 3'd5;

  localparam int CB_CLR   = 0;
  localparam int CB_ALLOW = 1;
  localparam int CB_OFF   = 2;
  localparam int CB_DAI   = 3;
  localparam int CB_RST   = 4;

  typedef logic [NUM_SRC-1:0][LVL_W-1:0] prio_vec_t;

  // highest set level of an in-service bitmap, 0 when idle
  function automatic logic [LVL_W-1:0] top_level(input logic [NUM_LVL-1:0] v);
    logic [LVL_W-1:0] r = '0;
    for (int i = 1; i < NUM_LVL; i++)
      if (v[i]) r = LVL_W'(i);
    return r;
  endfunction

  // bitmap with its highest level removed
  function automatic logic [NUM_LVL-1:0] drop_top(input logic [NUM_LVL-1:0] v);
    logic [NUM_LVL-1:0] r = v;
    logic [LVL_W-1:0]   t = top_level(v);
    if (t != '0) r[t] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output prio_vec_t         prio_o,
  output logic              ints_off_o,
  output logic              dai_on_o,
  output logic              clr_all_o,
  output logic              allow_o,
  output logic              rst_ctl_o,
  output logic              ret_wr_o
);
  logic ctl_wr;
  logic off_n_q, dai_n_q;
  prio_vec_t prio_q;

  assign ctl_wr    = wr_en && (wr_addr == OFS_CTRL);
  assign clr_all_o = ctl_wr && !wr_data[CB_CLR];
  assign allow_o   = ctl_wr && !wr_data[CB_ALLOW];
  assign rst_ctl_o = ctl_wr && !wr_data[CB_RST];
  assign ret_wr_o  = wr_en && (wr_addr == OFS_RET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_n_q <= 1'b1;
      dai_n_q <= 1'b1;
    end else if (ctl_wr) begin
      off_n_q <= wr_data[CB_OFF] | !wr_data[CB_RST];
      dai_n_q <= wr_data[CB_DAI] | !wr_data[CB_RST];
    end
  end

  for (genvar k = 0; k < NUM_PB; k++) begin : g_pbyte
    logic hit;
    assign hit = wr_en && (wr_addr == OFS_PRIO + ADDR_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[2*k]   <= '0;
        prio_q[2*k+1] <= '0;
      end else if (hit) begin
        prio_q[2*k]   <= wr_data[LVL_W-1:0];
        prio_q[2*k+1] <= wr_data[NIB +: LVL_W];
      end
    end
  end

  assign prio_o     = prio_q;
  assign ints_off_o = !off_n_q;
  assign dai_on_o   = !dai_n_q;
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
(
  input  logic [NUM_SRC-1:0] pend,
  input  prio_vec_t          prio,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx,
  output logic [LVL_W-1:0]   win_lvl
);
  always_comb begin
    win_lvl = '0;
    win_idx = '0;
    // walk downward so that ties settle on the lowest index
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i] && prio[i] != '0 && prio[i] >= win_lvl) begin
        win_lvl = prio[i];
        win_idx = IDX_W'(i);
      end
    end
    win_valid = (win_lvl != '0);
  end
endmodule

// File: rtl/pic_level_stack.sv
module pic_level_stack
  import pic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               push,
  input  logic [LVL_W-1:0]   push_lvl,
  input  logic               pop,
  output logic [NUM_LVL-1:0] insvc_o,
  output logic [LVL_W-1:0]   cur_lvl_o
);
  logic [NUM_LVL-1:0] q, after_pop, push_bit;

  assign after_pop = pop ? drop_top(q) : q;
  assign push_bit  = push ? (NUM_LVL'(1) << push_lvl) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else          q <= after_pop | push_bit;
  end

  assign insvc_o   = q;
  assign cur_lvl_o = top_level(q);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [IDX_W-1:0]  vec_o
);
  prio_vec_t          prio;
  logic               ints_off, dai_on, clr_all, allow, rst_ctl, ret_wr;
  logic [NUM_SRC-1:0] pend_q, pend_d, ack_clr;
  logic               win_valid, take, ack_take, blocked_q;
  logic [IDX_W-1:0]   win_idx, vec_q;
  logic [LVL_W-1:0]   win_lvl, irq_lvl_q, cur_lvl;
  logic [NUM_LVL-1:0] insvc;
  logic               irq_q;

  pic_cfg_regs u_cfg (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .prio_o(prio), .ints_off_o(ints_off), .dai_on_o(dai_on),
    .clr_all_o(clr_all), .allow_o(allow), .rst_ctl_o(rst_ctl), .ret_wr_o(ret_wr)
  );

  pic_arbiter u_arb (
    .pend(pend_q), .prio, .win_valid, .win_idx, .win_lvl
  );

  pic_level_stack u_stk (
    .clk, .rst_n, .clr(rst_ctl), .push(ack_take), .push_lvl(irq_lvl_q),
    .pop(ret_wr), .insvc_o(insvc), .cur_lvl_o(cur_lvl)
  );

  assign ack_take = ack_i && irq_q;
  assign take     = win_valid && (win_lvl > cur_lvl) && !ints_off && !blocked_q;
  assign ack_clr  = ack_take ? (NUM_SRC'(1) << vec_q) : '0;

  // a new request beats the acknowledge clear; clear-all and reset beat both
  assign pend_d = (clr_all || rst_ctl) ? '0 : ((pend_q & ~ack_clr) | req_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      blocked_q <= 1'b0;
      irq_q     <= 1'b0;
      vec_q     <= '0;
      irq_lvl_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (rst_ctl || allow)      blocked_q <= 1'b0;
      else if (ack_take && dai_on) blocked_q <= 1'b1;
      irq_q <= take && !ack_take && !rst_ctl;
      if (take) begin
        vec_q     <= win_idx;
        irq_lvl_q <= win_lvl;
      end
    end
  end

  assign irq_o = irq_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/pic_sva.sv
module pic_sva
  import pic_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               irq_o,
  input logic               ack_take,
  input logic               ints_off,
  input logic               blocked_q,
  input logic               clr_all,
  input logic               rst_ctl,
  input logic               ret_wr,
  input logic [NUM_LVL-1:0] insvc,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [LVL_W-1:0]   irq_lvl_q,
  input logic [LVL_W-1:0]   cur_lvl
);
  AST_PRIO_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_lvl_q != '0); // R3
  AST_IRQ_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_lvl_q > cur_lvl); // R6
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> !irq_o); // R7
  AST_RETURN_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_wr && !ack_take && !rst_ctl && insvc != '0) |=>
      ($countones(insvc) + 1 == $past($countones(insvc)))); // R8
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ints_off |=> !irq_o); // R9
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> pend_q == '0); // R10
  AST_BLOCK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_q |=> !irq_o); // R11
  AST_CTRL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ctl |=> (pend_q == '0 && insvc == '0 && !irq_o && !blocked_q)); // R12
endmodule

bind prio_irq_ctrl pic_sva u_sva (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .ack_take(ack_take),
  .ints_off(ints_off), .blocked_q(blocked_q), .clr_all(clr_all),
  .rst_ctl(rst_ctl), .ret_wr(ret_wr), .insvc(insvc), .pend_q(pend_q),
  .irq_lvl_q(irq_lvl_q), .cur_lvl(cur_lvl)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_i = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ack_i = 1'b0;
  logic       irq_o;
  logic [2:0] vec_o;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk, .rst_n, .req_i, .wr_en, .wr_addr, .wr_data, .ack_i, .irq_o, .vec_o
  );

  // {priority nibbles (nibble i = source index i), req mask, irq, vec}
  localparam logic [43:0] VEC_TBL [6] = '{
    {32'h00000500, 8'h04, 1'b1, 3'd2},
    {32'h07654321, 8'hFF, 1'b1, 3'd6},
    {32'h30000003, 8'h81, 1'b1, 3'd0},
    {32'h00000000, 8'h10, 1'b0, 3'd0},
    {32'h00006020, 8'h0A, 1'b1, 3'd3},
    {32'h07700000, 8'h60, 1'b1, 3'd5}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_req(input logic [7:0] m);
    req_i = m;
    @(negedge clk);
    req_i = '0;
  endtask

  task automatic do_ack();
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {irq,vec} actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_irq(input string tag, input logic exp_irq, input logic [2:0] exp_vec);
    if (exp_irq) chk(tag, {irq_o, vec_o}, {1'b1, exp_vec});
    else         chk(tag, {3'b000, irq_o}, 4'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    // R1 reset state
    chk("R1", {irq_o, vec_o}, 4'h0);
    rst_n = 1'b1;
    step(2);
    pulse_req(8'hFF);             // all priorities zero after reset
    step(3);
    chk_irq("R1_R3", 1'b0, 3'd0);

    // table: R2 mapping, R3, R4, R5
    foreach (VEC_TBL[e]) begin
      wr(3'd0, 8'hEF);
      for (int k = 0; k < 4; k++) wr(3'(k + 1), VEC_TBL[e][12 + 8*k +: 8]);
      pulse_req(VEC_TBL[e][11:4]);
      step(1);
      chk_irq("R2_R4_R5", VEC_TBL[e][3], VEC_TBL[e][2:0]);
    end
    // R2 high bits ignored: 0xF9 gives index1=7, index0=1
    wr(3'd0, 8'hEF);
    wr(3'd1, 8'hF9); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    pulse_req(8'h03);
    step(3);
    chk_irq("R2", 1'b1, 3'd1);

    // nesting: idx0=2, idx1=5, idx2=3, idx3=5
    wr(3'd0, 8'hEF);
    wr(3'd1, 8'h52); wr(3'd2, 8'h53);
    pulse_req(8'h01); step(3);
    chk_irq("R6", 1'b1, 3'd0);
    do_ack();
    chk_irq("R7", 1'b0, 3'd0);
    pulse_req(8'h02); step(3);
    chk_irq("R6", 1'b1, 3'd1);
    do_ack();
    pulse_req(8'h04); step(3);
    chk_irq("R6", 1'b0, 3'd0);     // level 3 below 5
    pulse_req(8'h08); step(3);
    chk_irq("R6", 1'b0, 3'd0);     // level 5 equal to 5
    wr(3'd5, 8'h00); step(3);
    chk_irq("R8", 1'b1, 3'd3);
    do_ack();
    wr(3'd5, 8'h00); step(3);
    chk_irq("R8", 1'b1, 3'd2);
    do_ack();
    wr(3'd5, 8'h00); wr(3'd5, 8'h00); step(3);
    chk_irq("R8", 1'b0, 3'd0);

    // R9 disable keeps flags
    wr(3'd0, 8'hFB);
    pulse_req(8'h01); step(3);
    chk_irq("R9", 1'b0, 3'd0);
    wr(3'd0, 8'hFF); step(3);
    chk_irq("R9", 1'b1, 3'd0);
    do_ack(); wr(3'd5, 8'h00);

    // R10 clear-all, including a same-cycle request
    wr(3'd0, 8'hFB);
    pulse_req(8'h02);
    wr(3'd0, 8'hFA);
    wr(3'd0, 8'hFF); step(3);
    chk_irq("R10", 1'b0, 3'd0);
    req_i = 8'h01;
    wr(3'd0, 8'hFE);
    req_i = '0;
    step(3);
    chk_irq("R10", 1'b0, 3'd0);

    // R11 disable-after-interrupt and re-arm
    wr(3'd0, 8'hF7);
    pulse_req(8'h01); step(3);
    chk_irq("R11", 1'b1, 3'd0);
    do_ack(); wr(3'd5, 8'h00);
    pulse_req(8'h01); step(3);
    chk_irq("R11", 1'b0, 3'd0);
    wr(3'd0, 8'hF5); step(3);
    chk_irq("R11", 1'b1, 3'd0);
    do_ack(); wr(3'd5, 8'h00);
    wr(3'd0, 8'hEF);

    // R7 acknowledge and same-source request in one cycle
    pulse_req(8'h01); step(3);
    chk_irq("R7", 1'b1, 3'd0);
    req_i = 8'h01;
    do_ack();
    req_i = '0;
    chk_irq("R7", 1'b0, 3'd0);
    step(3);
    chk_irq("R7", 1'b0, 3'd0);
    wr(3'd5, 8'h00); step(3);
    chk_irq("R7", 1'b1, 3'd0);
    do_ack(); wr(3'd5, 8'h00);

    // R12 controller reset pulse
    pulse_req(8'h02); step(3);
    chk_irq("R12", 1'b1, 3'd1);
    wr(3'd0, 8'hFB);
    wr(3'd0, 8'hEF); step(3);
    chk_irq("R12", 1'b0, 3'd0);
    pulse_req(8'h02); step(3);
    chk_irq("R12", 1'b1, 3'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule